// File: doc/BRIEF.md
# Card Clock Generator

This block makes the bus clock for a memory card. It runs on a sampling clock at twice the reference rate. It divides the reference by a power of two picked with a 3-bit divide code, and it opens or closes the clock gate when a control word is written. The output clock is `card_clk`. Each of its phases lasts 2^code sampling cycles, so the output rate is the reference rate divided by 2^code. The slowest setting, code 7, gives the reference divided by 128.

A control write carries three strobes. Bit 0 requests a stop, bit 1 requests a start and bit 2 requests an operation start. The strobes act only in the cycle of the write. The status output `clk_running` reports whether the gate is open. It goes high on the edge that accepts a start. It goes low on the same edge that the gate closes. When a start is accepted together with the operation strobe, a one-cycle `op_start` pulse goes to the command engine once the clock is running.

A small state machine sequences the gate. It has three states:
- `CK_IDLE`: the gate is closed and the output is low.
- `CK_RUN`: the divider toggles the output.
- `CK_DRAIN`: a stop has arrived during a high phase, and the block waits for that phase to finish.

It has these transitions:
- `IDLE->RUN` (start accepted).
- `RUN->IDLE` (stop while low, or stop on the last cycle of a high phase).
- `RUN->DRAIN` (stop during a high phase).
- `DRAIN->IDLE` (high phase complete).

Top module: `card_clk_gen`

## Requirements
- R1: After reset `card_clk`, `clk_running` and `op_start` are 0 and the stored divide code is 0.
- R2: A start with code c is accepted at a clock edge. After that edge `card_clk` stays low for 2^c sampling cycles, then toggles every 2^c sampling cycles: period 2^(c+1) sampling cycles.
- R3: A stop that arrives while `card_clk` is low closes the gate on the edge that samples it. It cuts the low phase short, and no further edge follows. `clk_running` falls on that edge.
- R4: A stop that arrives while `card_clk` is high lets the high phase run its full 2^c cycles. The output then falls, and `clk_running` falls on that same edge.
- R5: When the stop strobe (bit 0) and the start strobe (bit 1) come in the same write, the stop wins. From idle nothing starts and no operation pulse follows. While running, the write acts as a plain stop.
- R6: When the operation strobe (bit 2) comes with an accepted start, `op_start` is high for exactly one cycle, the cycle after `clk_running` rises. The operation strobe with no accepted start gives no pulse.
- R7: A divide code written while the clock runs does not change the running period. The next accepted start uses it, with the divider counter restarted from zero.
- R8: A start written while the clock already runs is ignored. The output schedule is unchanged and no operation pulse follows.
- R9: A stop written while the clock is stopped has no effect. The output stays low and the status stays 0.
- R10: `clk_running` is 1 from the start-accepting edge until the edge that closes the gate. While it is 0, `card_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_bits | input | 3 | Control strobes: bit 0 stop, bit 1 start, bit 2 operation start |
| div_wr | input | 1 | Divide-code write strobe |
| div_code | input | CODE_W | Divide code: phase length 2^code sampling cycles |
| card_clk | output | 1 | Gated, divided card clock |
| clk_running | output | 1 | Status: gate open |
| op_start | output | 1 | One-cycle operation-start pulse |

## Verification
The bench aims at the two ways a stop can land. A stop during a low phase must end the clock at once. A design that waits for the phase instead would show one extra rising edge. A stop during a high phase must finish that phase in full, and a design that cuts it short would emit a runt pulse that the edge scoreboard times as too short. A combined start-and-stop write, a start issued while the clock runs, and a divide code changed in mid-run are each checked against the expected edge schedule. A wrong priority, a restart or a late code update shows up as a moved edge or a stray operation pulse.

// File: rtl/cc_pkg.sv
package cc_pkg;

    // Control strobe positions; software writes these bits
    localparam int CTL_STOP  = 0;
    localparam int CTL_START = 1;
    localparam int CTL_OP    = 2;
    localparam int CTL_W     = 3;

    typedef enum logic [1:0] {
        CK_IDLE  = 2'd0,
        CK_RUN   = 2'd1,
        CK_DRAIN = 2'd2
    } ck_state_t;

endpackage

// File: rtl/cc_code_regs.sv
module cc_code_regs #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_wr,
    input  logic [CODE_W-1:0] div_code,
    input  logic              load,
    output logic [CODE_W-1:0] act_code
);

    logic [CODE_W-1:0] staged_code;

    // Staged code follows every write; the divider only sees it at a start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_code <= '0;
            act_code    <= '0;
        end else begin
            if (div_wr) staged_code <= div_code;
            if (load)   act_code    <= staged_code;
        end
    end

endmodule

// File: rtl/cc_div.sv
module cc_div #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              card_clk,
    output logic              phase_end
);

    localparam int MAX_SHIFT = (1 << CODE_W) - 1;
    localparam int CNT_W     = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Last count of a phase: 2^code - 1
    assign limit     = ~({CNT_W{1'b1}} << code);
    assign phase_end = (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            card_clk <= 1'b0;
        end else if (restart) begin
            cnt      <= '0;
            card_clk <= 1'b0;
        end else if (run) begin
            if (phase_end) begin
                cnt      <= '0;
                card_clk <= ~card_clk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cc_fsm.sv
module cc_fsm
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_bits,
    input  logic              card_clk,
    input  logic              phase_end,
    output logic              div_run,
    output logic              div_restart,
    output logic              accept,
    output logic              running,
    output logic              op_start
);

    ck_state_t state, state_nxt;
    logic      stop_req, start_req, op_req;
    logic      op_pend;

    assign stop_req  = ctl_wr & ctl_bits[CTL_STOP];
    assign start_req = ctl_wr & ctl_bits[CTL_START];
    assign op_req    = ctl_wr & ctl_bits[CTL_OP];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CK_IDLE;
        else        state <= state_nxt;
    end

    // Next state and divider controls
    always_comb begin
        state_nxt   = state;
        div_run     = 1'b0;
        div_restart = 1'b0;
        accept      = 1'b0;
        unique case (state)
            CK_IDLE: begin
                if (start_req && !stop_req) begin
                    state_nxt   = CK_RUN;
                    div_restart = 1'b1;
                    accept      = 1'b1;
                end
            end
            CK_RUN: begin
                div_run = 1'b1;
                if (stop_req) begin
                    if (!card_clk) begin
                        state_nxt = CK_IDLE;
                        div_run   = 1'b0;
                    end else if (phase_end) begin
                        state_nxt = CK_IDLE;
                    end else begin
                        state_nxt = CK_DRAIN;
                    end
                end
            end
            CK_DRAIN: begin
                div_run = 1'b1;
                if (phase_end) state_nxt = CK_IDLE;
            end
            default: state_nxt = CK_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_pend  <= 1'b0;
            op_start <= 1'b0;
        end else begin
            op_pend  <= accept & op_req;
            op_start <= op_pend;
        end
    end

    assign running = (state != CK_IDLE);

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import cc_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [2:0]        ctl_bits,
    input  logic              div_wr,
    input  logic [CODE_W-1:0] div_code,
    output logic              card_clk,
    output logic              clk_running,
    output logic              op_start
);

    logic              div_run, div_restart, accept, phase_end;
    logic [CODE_W-1:0] act_code;

    cc_code_regs #(.CODE_W(CODE_W)) u_codes (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_code (div_code),
        .load     (accept),
        .act_code (act_code)
    );

    cc_div #(.CODE_W(CODE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (div_restart),
        .run       (div_run),
        .code      (act_code),
        .card_clk  (card_clk),
        .phase_end (phase_end)
    );

    cc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_bits    (ctl_bits),
        .card_clk    (card_clk),
        .phase_end   (phase_end),
        .div_run     (div_run),
        .div_restart (div_restart),
        .accept      (accept),
        .running     (clk_running),
        .op_start    (op_start)
    );

endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic [2:0]        ctl_bits,
    input logic              div_wr,
    input logic [CODE_W-1:0] div_code,
    input logic              card_clk,
    input logic              clk_running,
    input logic              op_start
);

    localparam int LEN_W = (1 << CODE_W) + 1;

    logic              accept_w;
    logic [CODE_W-1:0] sh_div, sh_act;
    logic              clk_d;
    logic [LEN_W-1:0]  run_len;
    logic [LEN_W-1:0]  half_len;

    assign accept_w = ctl_wr && ctl_bits[1] && !ctl_bits[0] && !clk_running;
    assign half_len = LEN_W'(1) << sh_act;

    // Port-level shadow of the code and a measure of each phase length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_div  <= '0;
            sh_act  <= '0;
            clk_d   <= 1'b0;
            run_len <= '0;
        end else begin
            if (div_wr)   sh_div <= div_code;
            if (accept_w) sh_act <= sh_div;
            clk_d <= card_clk;
            if (accept_w)                run_len <= '0;
            else if (card_clk != clk_d)  run_len <= LEN_W'(1);
            else if (run_len != '1)      run_len <= run_len + 1'b1;
        end
    end

    // R2 R4 R7: every completed phase lasts exactly 2^code cycles
    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk != clk_d) |-> (run_len == half_len));

    a_r3_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_running) |-> !card_clk);

    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_running |-> !card_clk);

    a_r10_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        accept_w |=> clk_running);

    // R5 R9: a stop seen while idle keeps the clock stopped
    a_r9_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_bits[0] && !clk_running) |=> !clk_running);

    a_r6_op_due: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_w && ctl_bits[2]) |=> ##1 op_start);

    // R6 R8: a pulse only two cycles after an idle-to-running start
    a_r6_op_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($past(clk_running) && !$past(clk_running, 2)));

    a_r6_op_single: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

endmodule

bind card_clk_gen card_clk_gen_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_bits    (ctl_bits),
    .div_wr      (div_wr),
    .div_code    (div_code),
    .card_clk    (card_clk),
    .clk_running (clk_running),
    .op_start    (op_start)
);

// File: tb/sim_card_clk_gen.sv
module sim_card_clk_gen;

    localparam int CLK_PERIOD = 10;

    bit       clk = 1'b0;
    bit       rst_n = 1'b0;
    bit       ctl_wr = 1'b0;
    bit [2:0] ctl_bits = 3'b000;
    bit       div_wr = 1'b0;
    bit [2:0] div_code = 3'b000;
    logic     card_clk, clk_running, op_start;

    card_clk_gen #(.CODE_W(3)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_bits    (ctl_bits),
        .div_wr      (div_wr),
        .div_code    (div_code),
        .card_clk    (card_clk),
        .clk_running (clk_running),
        .op_start    (op_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // kind: 0 falling edge, 1 rising edge, 2 operation pulse
    typedef struct {int cyc; int kind;} exp_t;
    exp_t exp_q[$];
    exp_t front;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   prev_clk = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: pops the scoreboard on every observed event
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (op_start === 1'b1) begin
                if (exp_q.size() == 0) check(1'b0, "R6/R8 unexpected op pulse", cyc, -1);
                else begin
                    front = exp_q[0];
                    if (front.kind == 2) begin
                        void'(exp_q.pop_front());
                        check(front.cyc == cyc, "R6 op pulse cycle", cyc, front.cyc);
                    end else check(1'b0, "R6/R8 op pulse not expected here", cyc, front.cyc);
                end
            end
            if (card_clk !== prev_clk) begin
                if (exp_q.size() == 0) check(1'b0, "R3/R4 unexpected card clock edge", cyc, -1);
                else begin
                    front = exp_q[0];
                    void'(exp_q.pop_front());
                    check(front.kind == int'(card_clk) && front.cyc == cyc,
                          "R2/R7 card clock edge cycle", cyc, front.cyc);
                end
            end
            prev_clk = card_clk;
        end
    end

    // Driver: called at a falling edge, returns the cycle count at the drive
    task automatic drive(input bit cw, input bit [2:0] bits, input bit dw,
                         input bit [2:0] code, output int s);
        ctl_wr = cw; ctl_bits = bits; div_wr = dw; div_code = code;
        s = cyc;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_bits = 3'b000; div_wr = 1'b0; div_code = 3'b000;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic run_seq(input int code, input bit op, input int nhalf,
                           input bit mid_start, input int mid_code, input bit stop_both);
        int h, s, t, last;
        h = 1 << code;
        drive(1'b1, {op, 2'b10}, 1'b0, 3'b000, s);
        if (op) exp_q.push_back('{s + 2, 2});
        for (int i = 1; i <= nhalf; i++) exp_q.push_back('{s + 1 + h * i, i % 2});
        check(clk_running === 1'b1, "R10 running after accepted start", int'(clk_running), 1);
        last = s + 1 + h * nhalf;
        if (mid_start || mid_code >= 0) begin
            wait_cyc(s + 1 + h);
            // R7 code write / R8 start+op while running
            drive(mid_start, 3'b110, mid_code >= 0, 3'(mid_code), t);
        end
        wait_cyc(last);
        // R5 when stop_both: start bit rides along, stop must win
        drive(1'b1, stop_both ? 3'b011 : 3'b001, 1'b0, 3'b000, t);
        if (nhalf % 2 == 1) begin
            exp_q.push_back('{last + h, 0});
            if (h > 1) begin
                wait_cyc(last + h - 1);
                check(clk_running === 1'b1 && card_clk === 1'b1,
                      "R4 high phase completes before gate closes", int'(card_clk), 1);
            end
            wait_cyc(last + h);
            check(clk_running === 1'b0, "R4 status falls with the gate", int'(clk_running), 0);
        end else begin
            check(clk_running === 1'b0, "R3 status falls at once in low phase", int'(clk_running), 0);
        end
        repeat (2 * h + 4) @(negedge clk);
        check(card_clk === 1'b0 && exp_q.size() == 0,
              "R3/R4 clock stays low and all events seen", exp_q.size(), 0);
    endtask

    initial begin
        int t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(card_clk === 1'b0, "R1 card_clk after reset", int'(card_clk), 0);
        check(clk_running === 1'b0, "R1 running after reset", int'(clk_running), 0);
        check(op_start === 1'b0, "R1 op_start after reset", int'(op_start), 0);

        // R1 code 0 from reset, R2 fastest rate, op pulse, stop in low phase
        run_seq(0, 1'b1, 4, 1'b0, -1, 1'b0);
        // R2 code 3, stop in high phase (R4)
        drive(1'b0, 3'b000, 1'b1, 3'd3, t);
        run_seq(3, 1'b0, 5, 1'b0, -1, 1'b0);
        // R2 slowest code, R5 start+stop while running acts as stop
        drive(1'b0, 3'b000, 1'b1, 3'd7, t);
        run_seq(7, 1'b1, 2, 1'b0, -1, 1'b1);
        // R7 code changed in mid-run: ignored now, used at next start
        drive(1'b0, 3'b000, 1'b1, 3'd2, t);
        run_seq(2, 1'b1, 4, 1'b0, 5, 1'b0);
        run_seq(5, 1'b0, 3, 1'b0, -1, 1'b0);
        // R8 start+op while running: no restart, no pulse
        drive(1'b0, 3'b000, 1'b1, 3'd1, t);
        run_seq(1, 1'b1, 6, 1'b1, -1, 1'b0);

        // R5 start and stop together from idle
        drive(1'b1, 3'b111, 1'b0, 3'b000, t);
        check(clk_running === 1'b0, "R5 stop wins over start in idle", int'(clk_running), 0);
        repeat (6) @(negedge clk);
        check(clk_running === 1'b0 && card_clk === 1'b0, "R5 clock still stopped",
              int'(card_clk), 0);
        // R9 stop while idle
        drive(1'b1, 3'b001, 1'b0, 3'b000, t);
        repeat (4) @(negedge clk);
        check(clk_running === 1'b0 && card_clk === 1'b0, "R9 idle stop has no effect",
              int'(clk_running), 0);
        // R6 operation strobe without start
        drive(1'b1, 3'b100, 1'b0, 3'b000, t);
        repeat (4) @(negedge clk);
        check(clk_running === 1'b0, "R6 op strobe alone starts nothing", int'(clk_running), 0);

        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule